// File: doc/BRIEF.md
# DMA Channel Error and Halt Controller

This block is the control state machine of one DMA channel. It sits between the channel's transfer engines and its interrupt status bank and decides how the channel reacts to errors and software requests. Bus errors returned to the transfer master retire the channel through a graceful disable. Programming errors do not retire it; they park it in a halted state until software writes the resume register. Software can also enable, disable, suspend, unsuspend and abort the channel.

Graceful actions wait for the last outstanding bus beat (`bus_busy` low) before they take effect. Abort acts at once. A descriptor found invalid during a prefetch is not reported at that point. Instead the block asks the fetch logic to fetch it again once the current block is done, and only an invalid result on that non-prefetch fetch halts the channel. Every pin is a plain level or a one-cycle strobe. The block carries no data stream, so no port has a valid/ready handshake. All outputs are registered and change on the clock edge that samples the causing input.

Top module: `dma_ch_err_halt`

## Requirements
- R1: After reset, every output is 0 and the channel is disabled.
- R2: `sw_enable` while disabled sets `ch_en` after one edge and clears `lock_cleared`. While the channel is enabled, `sw_enable` has no effect.
- R3: A transfer error on any bit of `xfer_err` while enabled starts a drain. `ch_en` stays 1 while `bus_busy` is 1. On the first drain edge with `bus_busy` at 0, `ch_en` falls, and `ev_disabled` and `ev_lock_cleared` pulse for one cycle.
- R4: `sw_disable` drains the same way and clears the lock. `lock_cleared` goes to 1 when a graceful disable completes and holds until the next `sw_enable` from the disabled state.
- R5: `sw_abort` in any enabled state, including a drain, clears `ch_en` and pulses `ev_aborted` on the next edge. It does not wait for `bus_busy` and does not clear the lock.
- R6: A multiblock-type error (`mblk_err`), or a descriptor check with `desc_vld`=0 and `desc_pref`=0, while active drains the channel. It then sets `ch_halted` and pulses `ev_halted`, and `ch_en` stays 1. The descriptor case also pulses `ev_desc_invalid` one edge after the check.
- R7: `resume_wr` in the halted state returns the channel to active. In any other state it has no effect.
- R8: A descriptor check with `desc_vld`=0 and `desc_pref`=1 raises no event and is deferred. The next `blk_done` while enabled pulses `refetch_req` and drops the deferral. A check with `desc_vld`=1 also drops it.
- R9: `sw_suspend` while active pulses `ev_src_suspended` at once. When the drain ends, `ch_suspended` is set and `ev_suspended` pulses. `sw_unsuspend` returns a suspended channel to active.
- R10: Requests arriving in the same cycle rank abort > transfer error > software disable > halt cause > suspend. During a drain, a request of higher rank replaces the pending one, and completion waits at least one more edge.
- R11: While disabled, transfer errors, halt causes, abort, suspend and resume change no output.
- R12: While halted or suspended, halt causes and `sw_suspend` are ignored. Transfer errors and `sw_disable` still lead to a graceful disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Software enable strobe |
| sw_disable | input | 1 | Software graceful-disable strobe |
| sw_abort | input | 1 | Software abort strobe |
| sw_suspend | input | 1 | Software suspend strobe |
| sw_unsuspend | input | 1 | Software suspend-release strobe |
| resume_wr | input | 1 | Write strobe of the block-resume register |
| xfer_err | input | NUM_XERR | Decode/slave error pulses from source, destination and descriptor read/write accesses |
| mblk_err | input | 1 | Invalid multiblock type detected |
| desc_chk | input | 1 | Descriptor validity check strobe |
| desc_vld | input | 1 | Valid bit of the checked descriptor |
| desc_pref | input | 1 | Checked descriptor came from a prefetch |
| blk_done | input | 1 | Current block finished |
| bus_busy | input | 1 | A bus beat is still outstanding |
| ch_en | output | 1 | Channel enable |
| ch_halted | output | 1 | Halted, waiting for a resume write |
| ch_suspended | output | 1 | Suspended |
| lock_cleared | output | 1 | Channel lock was cleared by a disable |
| ev_aborted | output | 1 | Abort event pulse |
| ev_disabled | output | 1 | Graceful disable completed pulse |
| ev_lock_cleared | output | 1 | Lock-cleared event pulse |
| ev_halted | output | 1 | Halt completed pulse |
| ev_suspended | output | 1 | Suspend completed pulse |
| ev_src_suspended | output | 1 | Source side stopped pulse |
| ev_desc_invalid | output | 1 | Invalid descriptor reported pulse |
| refetch_req | output | 1 | Request to refetch a deferred descriptor |

## Verification
The hardest situation to reach is a drain whose pending action is overtaken. A suspend or halt must be pending with `bus_busy` held high, and then a transfer error, a software disable or an abort must arrive before the bus goes idle. The directed phase holds `bus_busy` high across several edges and injects the stronger request partway through. A second directed case defers an invalid prefetched descriptor and then releases it with `blk_done`. A long weighted random phase follows, with the reference model compared on every cycle.

// File: rtl/chh_pkg.sv
package chh_pkg;
  // Request kinds; numeric order is the priority order (higher wins).
  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_SUSP   = 3'd1,
    K_HALT   = 3'd2,
    K_SWDIS  = 3'd3,
    K_ERRDIS = 3'd4,
    K_ABORT  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ACTIVE = 3'd1,
    S_DRAIN  = 3'd2,
    S_HALTED = 3'd3,
    S_SUSP   = 3'd4
  } state_e;
endpackage

// File: rtl/chh_req_arb.sv
module chh_req_arb
  import chh_pkg::*;
(
  input  logic  en_any,
  input  logic  soft_ok,
  input  logic  abort_i,
  input  logic  xerr_i,
  input  logic  swdis_i,
  input  logic  halt_i,
  input  logic  susp_i,
  output kind_e req_o
);
  // Fixed-rank selection; soft causes only count while the channel runs.
  always_comb begin
    req_o = K_NONE;
    if (en_any) begin
      if (abort_i)                  req_o = K_ABORT;
      else if (xerr_i)              req_o = K_ERRDIS;
      else if (swdis_i)             req_o = K_SWDIS;
      else if (halt_i && soft_ok)   req_o = K_HALT;
      else if (susp_i && soft_ok)   req_o = K_SUSP;
    end
  end
endmodule

// File: rtl/chh_prefetch_defer.sv
module chh_prefetch_defer (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic en_i,
  input  logic restart_i,
  input  logic chk_i,
  input  logic vld_i,
  input  logic pref_i,
  input  logic blk_done_i,
  output logic refetch_o
);
  logic defer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_q   <= 1'b0;
      refetch_o <= 1'b0;
    end else begin
      refetch_o <= 1'b0;
      if (restart_i) begin
        defer_q <= 1'b0;
      end else if (blk_done_i && defer_q && en_i) begin
        refetch_o <= 1'b1;
        defer_q   <= 1'b0;
      end else if (active_i && chk_i && !vld_i && pref_i) begin
        defer_q <= 1'b1;
      end else if (chk_i && vld_i) begin
        defer_q <= 1'b0;
      end
    end
  end

  // R8: a refetch request only follows a block completion
  assert_refetch_after_blk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refetch_o |-> $past(blk_done_i));
endmodule

// File: rtl/dma_ch_err_halt.sv
module dma_ch_err_halt
  import chh_pkg::*;
#(
  parameter int NUM_XERR = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_enable,
  input  logic                sw_disable,
  input  logic                sw_abort,
  input  logic                sw_suspend,
  input  logic                sw_unsuspend,
  input  logic                resume_wr,
  input  logic [NUM_XERR-1:0] xfer_err,
  input  logic                mblk_err,
  input  logic                desc_chk,
  input  logic                desc_vld,
  input  logic                desc_pref,
  input  logic                blk_done,
  input  logic                bus_busy,
  output logic                ch_en,
  output logic                ch_halted,
  output logic                ch_suspended,
  output logic                lock_cleared,
  output logic                ev_aborted,
  output logic                ev_disabled,
  output logic                ev_lock_cleared,
  output logic                ev_halted,
  output logic                ev_suspended,
  output logic                ev_src_suspended,
  output logic                ev_desc_invalid,
  output logic                refetch_req
);
  state_e st;
  kind_e  pend, req;
  logic   xerr_any, bad_desc, halt_cause;

  assign xerr_any   = |xfer_err;
  assign bad_desc   = desc_chk && !desc_vld && !desc_pref;
  assign halt_cause = mblk_err || bad_desc;

  chh_req_arb u_arb (
    .en_any  (st != S_IDLE),
    .soft_ok (st == S_ACTIVE),
    .abort_i (sw_abort),
    .xerr_i  (xerr_any),
    .swdis_i (sw_disable),
    .halt_i  (halt_cause),
    .susp_i  (sw_suspend),
    .req_o   (req)
  );

  chh_prefetch_defer u_defer (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (st == S_ACTIVE),
    .en_i       (st != S_IDLE),
    .restart_i  ((st == S_IDLE) && sw_enable),
    .chk_i      (desc_chk),
    .vld_i      (desc_vld),
    .pref_i     (desc_pref),
    .blk_done_i (blk_done),
    .refetch_o  (refetch_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st               <= S_IDLE;
      pend             <= K_NONE;
      lock_cleared     <= 1'b0;
      ev_aborted       <= 1'b0;
      ev_disabled      <= 1'b0;
      ev_lock_cleared  <= 1'b0;
      ev_halted        <= 1'b0;
      ev_suspended     <= 1'b0;
      ev_src_suspended <= 1'b0;
      ev_desc_invalid  <= 1'b0;
    end else begin
      ev_aborted       <= 1'b0;
      ev_disabled      <= 1'b0;
      ev_lock_cleared  <= 1'b0;
      ev_halted        <= 1'b0;
      ev_suspended     <= 1'b0;
      ev_src_suspended <= 1'b0;
      ev_desc_invalid  <= (st == S_ACTIVE) && bad_desc;
      case (st)
        S_IDLE: begin
          if (sw_enable) begin
            st           <= S_ACTIVE;
            lock_cleared <= 1'b0;
          end
        end
        S_ACTIVE, S_HALTED, S_SUSP: begin
          if (req == K_ABORT) begin
            st         <= S_IDLE;
            ev_aborted <= 1'b1;
          end else if (req != K_NONE) begin
            st   <= S_DRAIN;
            pend <= req;
            if (req == K_SUSP) ev_src_suspended <= 1'b1;
          end else if (st == S_HALTED && resume_wr) begin
            st <= S_ACTIVE;
          end else if (st == S_SUSP && sw_unsuspend) begin
            st <= S_ACTIVE;
          end
        end
        S_DRAIN: begin
          if (req == K_ABORT) begin
            st         <= S_IDLE;
            ev_aborted <= 1'b1;
          end else if (req > pend) begin
            pend <= req;
          end else if (!bus_busy) begin
            case (pend)
              K_SWDIS, K_ERRDIS: begin
                st              <= S_IDLE;
                ev_disabled     <= 1'b1;
                ev_lock_cleared <= 1'b1;
                lock_cleared    <= 1'b1;
              end
              K_HALT: begin
                st        <= S_HALTED;
                ev_halted <= 1'b1;
              end
              default: begin
                st           <= S_SUSP;
                ev_suspended <= 1'b1;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ch_en        = (st != S_IDLE);
  assign ch_halted    = (st == S_HALTED);
  assign ch_suspended = (st == S_SUSP);

  // R5: abort takes effect on the next edge regardless of bus activity
  assert_abort_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && sw_abort) |=> (!ch_en && ev_aborted));
  // R3: a drain with a beat outstanding keeps the channel enabled
  assert_drain_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && bus_busy && !sw_abort) |=> ch_en);
  // R11: only an enable request can wake a disabled channel
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !sw_enable) |=> (!ch_en && !ev_aborted && !ev_halted));
  // R7: a halted channel stays halted without resume or a stronger request
  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_halted && !resume_wr && !sw_abort && !xerr_any && !sw_disable) |=> ch_halted);
  // R4: the lock-cleared state persists until re-enable
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cleared && !sw_enable) |=> lock_cleared);
  // R8: a prefetched invalid descriptor is never reported directly
  assert_pref_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_chk && !desc_vld && desc_pref) |=> !ev_desc_invalid);
endmodule

// File: tb/dma_ch_err_halt_bench.sv
module dma_ch_err_halt_bench;
  localparam int NX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_enable = 0, sw_disable = 0, sw_abort = 0, sw_suspend = 0, sw_unsuspend = 0;
  logic resume_wr = 0, mblk_err = 0, desc_chk = 0, desc_vld = 0, desc_pref = 0;
  logic blk_done = 0, bus_busy = 0;
  logic [NX-1:0] xfer_err = '0;
  logic ch_en, ch_halted, ch_suspended, lock_cleared;
  logic ev_aborted, ev_disabled, ev_lock_cleared, ev_halted, ev_suspended;
  logic ev_src_suspended, ev_desc_invalid, refetch_req;

  always #5 clk = ~clk;

  dma_ch_err_halt #(.NUM_XERR(NX)) u_dma_ch_err_halt (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .sw_disable(sw_disable),
    .sw_abort(sw_abort), .sw_suspend(sw_suspend), .sw_unsuspend(sw_unsuspend),
    .resume_wr(resume_wr), .xfer_err(xfer_err), .mblk_err(mblk_err),
    .desc_chk(desc_chk), .desc_vld(desc_vld), .desc_pref(desc_pref),
    .blk_done(blk_done), .bus_busy(bus_busy), .ch_en(ch_en), .ch_halted(ch_halted),
    .ch_suspended(ch_suspended), .lock_cleared(lock_cleared), .ev_aborted(ev_aborted),
    .ev_disabled(ev_disabled), .ev_lock_cleared(ev_lock_cleared), .ev_halted(ev_halted),
    .ev_suspended(ev_suspended), .ev_src_suspended(ev_src_suspended),
    .ev_desc_invalid(ev_desc_invalid), .refetch_req(refetch_req));

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string scen = "R1";

  // Behavioural model: mode 0 off, 1 running, 2 draining, 3 halted, 4 suspended.
  int mode, want;
  bit m_lock, m_defer;
  bit e_abt, e_dis, e_lck, e_hlt, e_sus, e_src, e_inv, e_ref;

  task automatic model_reset();
    mode = 0; want = 0; m_lock = 0; m_defer = 0;
    {e_abt, e_dis, e_lck, e_hlt, e_sus, e_src, e_inv, e_ref} = '0;
  endtask

  task automatic model_step();
    int r;
    bit on, bad;
    on  = (mode != 0);
    bad = desc_chk && !desc_vld && !desc_pref;
    {e_abt, e_dis, e_lck, e_hlt, e_sus, e_src, e_ref} = '0;
    e_inv = (mode == 1) && bad;
    if (mode == 0 && sw_enable) m_defer = 0;
    else if (blk_done && m_defer && on) begin e_ref = 1; m_defer = 0; end
    else if (mode == 1 && desc_chk && !desc_vld && desc_pref) m_defer = 1;
    else if (desc_chk && desc_vld) m_defer = 0;
    r = 0;
    if (on) begin
      if (mode == 1 && sw_suspend) r = 1;
      if (mode == 1 && (mblk_err || bad)) r = 2;
      if (sw_disable) r = 3;
      if (xfer_err != 0) r = 4;
      if (sw_abort) r = 5;
    end
    if (mode == 0) begin
      if (sw_enable) begin mode = 1; m_lock = 0; end
    end else if (mode == 2) begin
      if (r == 5) begin mode = 0; e_abt = 1; end
      else if (r > want) want = r;
      else if (!bus_busy) begin
        if (want >= 3) begin mode = 0; e_dis = 1; e_lck = 1; m_lock = 1; end
        else if (want == 2) begin mode = 3; e_hlt = 1; end
        else begin mode = 4; e_sus = 1; end
      end
    end else begin
      if (r == 5) begin mode = 0; e_abt = 1; end
      else if (r != 0) begin want = r; mode = 2; if (r == 1) e_src = 1; end
      else if (mode == 3 && resume_wr) mode = 1;
      else if (mode == 4 && sw_unsuspend) mode = 1;
    end
  endtask

  task automatic chk(input logic got, input bit exp, input string name, input string req);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s (%s) %s got %0b exp %0b at %0t", req, scen, name, got, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    chk(ch_en, mode != 0, "ch_en", "R2");
    chk(ch_halted, mode == 3, "ch_halted", "R6");
    chk(ch_suspended, mode == 4, "ch_suspended", "R9");
    chk(lock_cleared, m_lock, "lock_cleared", "R4");
    chk(ev_aborted, e_abt, "ev_aborted", "R5");
    chk(ev_disabled, e_dis, "ev_disabled", "R3");
    chk(ev_lock_cleared, e_lck, "ev_lock_cleared", "R4");
    chk(ev_halted, e_hlt, "ev_halted", "R6");
    chk(ev_suspended, e_sus, "ev_suspended", "R9");
    chk(ev_src_suspended, e_src, "ev_src_suspended", "R9");
    chk(ev_desc_invalid, e_inv, "ev_desc_invalid", "R6");
    chk(refetch_req, e_ref, "refetch_req", "R8");
  endtask

  // Inputs were set at a falling edge; the model takes the same edge, outputs compared at the next fall.
  task automatic go();
    model_step();
    @(negedge clk);
    compare();
    {sw_enable, sw_disable, sw_abort, sw_suspend, sw_unsuspend, resume_wr} = '0;
    {mblk_err, desc_chk, desc_vld, desc_pref, blk_done} = '0;
    xfer_err = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) go();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    scen = "R1"; compare();                          // R1 reset state
    idle(1);
    scen = "R11";                                    // R11 stimuli while disabled
    sw_abort = 1; xfer_err = 8'h04; go();
    mblk_err = 1; desc_chk = 1; sw_suspend = 1; resume_wr = 1; go();
    scen = "R2"; sw_enable = 1; go(); sw_enable = 1; go(); idle(1);
    scen = "R8";                                     // deferred prefetch invalid
    desc_chk = 1; desc_pref = 1; go(); idle(2);
    blk_done = 1; go(); idle(1); blk_done = 1; go();
    desc_chk = 1; desc_pref = 1; go(); desc_chk = 1; desc_vld = 1; go();
    blk_done = 1; go();
    scen = "R6"; bus_busy = 1;                       // non-prefetch invalid halts after drain
    desc_chk = 1; go(); resume_wr = 1; go(); idle(1); bus_busy = 0; go(); idle(1);
    scen = "R12"; mblk_err = 1; go(); sw_suspend = 1; go(); desc_chk = 1; go();
    scen = "R7"; resume_wr = 1; go(); resume_wr = 1; go();
    scen = "R12"; mblk_err = 1; go(); go(); xfer_err = 8'h80; go(); idle(2);
    scen = "R3"; sw_enable = 1; go(); bus_busy = 1; xfer_err = 8'h01; go(); idle(3);
    bus_busy = 0; go(); idle(1);
    scen = "R4"; sw_enable = 1; go(); sw_disable = 1; go(); idle(2);
    scen = "R5"; sw_enable = 1; go(); bus_busy = 1; sw_suspend = 1; go(); idle(1);
    sw_abort = 1; go(); bus_busy = 0; idle(1);
    scen = "R10"; sw_enable = 1; go(); sw_abort = 1; xfer_err = 8'h10; go();
    sw_enable = 1; go(); sw_disable = 1; mblk_err = 1; xfer_err = 8'h02; go(); idle(2);
    sw_enable = 1; go(); bus_busy = 1; sw_suspend = 1; go(); idle(1);
    sw_disable = 1; go(); bus_busy = 0; go(); idle(1);
    sw_enable = 1; go(); bus_busy = 1; mblk_err = 1; go(); sw_disable = 1; go();
    xfer_err = 8'h20; bus_busy = 0; go(); idle(2);
    scen = "R9"; sw_enable = 1; go(); sw_suspend = 1; go(); idle(2);
    sw_unsuspend = 1; go(); idle(1);
    scen = "random";
    for (int i = 0; i < 4000; i++) begin
      sw_enable    = ($urandom_range(99) < 20);
      sw_disable   = ($urandom_range(99) < 3);
      sw_abort     = ($urandom_range(99) < 2);
      sw_suspend   = ($urandom_range(99) < 4);
      sw_unsuspend = ($urandom_range(99) < 10);
      resume_wr    = ($urandom_range(99) < 10);
      mblk_err     = ($urandom_range(99) < 3);
      desc_chk     = ($urandom_range(99) < 12);
      desc_vld     = $urandom_range(1);
      desc_pref    = $urandom_range(1);
      blk_done     = ($urandom_range(99) < 8);
      bus_busy     = ($urandom_range(99) < 55);
      if ($urandom_range(99) < 3) xfer_err[$urandom_range(NX-1)] = 1'b1;
      go();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule